// File: doc/BRIEF.md
# Lagged-Fibonacci Random Wheel

This block produces a stream of 32-bit pseudo-random words for Monte Carlo acceptance tests, at up to one word per clock. Its state is a ring of 64 unsigned words, all held in registers. Each step does three things in one cycle:

- It adds two older ring entries to form a new word.
- It stores that word in place of the oldest entry.
- It sends out the new word XORed with a third, still older entry.

Before it can run, the block must be seeded with 64 words through a write port. The controller has three states:

- `ST_EMPTY`: after reset, nothing seeded.
- `ST_FILL`: seeding in progress.
- `ST_RUN`: generating.

The transitions are:

- `EMPTY→FILL` on the first seed write.
- `FILL→RUN` on the seed write that fills the last slot.
- `RUN→FILL` when a seed write arrives while running. This restarts the seeding.

No transition leaves `FILL` except completion, and none leaves `EMPTY` except a seed write.

Notation: W[i] is the i-th word of the sequence, and K is the index of the word being produced. Seed word number i, counted from 0, is W[i]. The first step computes W[64]. Step K computes:

- W[K] = W[K−24] + W[K−55] mod 2^32
- out = W[K] ^ W[K−61]

Top module: `lagfib_rng`

## Requirements
- R1: While reset is asserted and on release, `rnd_valid` is 0 and `rnd_out` is 0.
- R2: `rnd_valid` stays 0 until 64 seed words have been written. While seeding, `step_en` has no effect on the ring or the index: the first output after seeding equals the value computed from the seeds alone.
- R3: A step occurs on a clock edge where the state is `ST_RUN`, `step_en` is 1 and `seed_we` is 0. After such an edge, `rnd_valid` is 1 for exactly one cycle. After any other edge, `rnd_valid` is 0 and `rnd_out` keeps its value.
- R4: Seed words are numbered from 0 in write order: the n-th accepted seed write, counted from 0, is W[n]. Step K (the first step is K=64) outputs (W[K−24] + W[K−55] mod 2^32) XOR W[K−61] on `rnd_out`.
- R5: Each step replaces W[K−64] in the ring with W[K]. The recurrence therefore continues correctly through many wraps of the 64-entry ring, checked over more than 1000 outputs.
- R6: With `step_en` held at 1 in `ST_RUN`, one new valid word appears every cycle.
- R7: A seed write takes priority over a step. A seed write in `ST_RUN` returns the block to seeding: that word becomes W[0], `rnd_valid` is 0 in the following cycle, and 63 more words are needed before output resumes.
- R8: The addition drops its carry. Sums that exceed 2^32−1 wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| seed_we | input | 1 | Write `seed_data` as the next seed word |
| seed_data | input | 32 | Seed word |
| step_en | input | 1 | Request one generator step |
| rnd_out | output | 32 | Last generated random word |
| rnd_valid | output | 1 | `rnd_out` was produced on the previous edge |

## Verification
A wrong ring word or a misplaced write index changes the output of the next step that reads that slot. With taps at lags 24, 55 and 61, this happens within at most 61 steps. A bad tap address or a lost carry corrupts the very first output after seeding, and the whole sequence after it differs. Comparing every output against an independent model of the recurrence over many ring wraps therefore exposes any state error within one ring period. A state machine error shows up as `rnd_valid` appearing during seeding, or as output resuming too early after a reseed.

// File: rtl/lagfib_pkg.sv
package lagfib_pkg;
    localparam int WORD_W  = 32;
    localparam int RING_AW = 6;
    localparam int LAG_ADD_A = 24;
    localparam int LAG_ADD_B = 55;
    localparam int LAG_MIX   = 61;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_FILL  = 2'd1,
        ST_RUN   = 2'd2
    } wheel_state_t;
endpackage

// File: rtl/lagfib_ring.sv
module lagfib_ring #(
    parameter int DW = 32,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr_a,
    input  logic [AW-1:0] rd_addr_b,
    input  logic [AW-1:0] rd_addr_x,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b,
    output logic [DW-1:0] rd_x
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && wr_addr == AW'(g)) begin
                slot[g] <= wr_data;
            end
        end
    end

    assign rd_a = slot[rd_addr_a];
    assign rd_b = slot[rd_addr_b];
    assign rd_x = slot[rd_addr_x];
endmodule

// File: rtl/lagfib_mix.sv
module lagfib_mix #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] tap_a,
    input  logic [DW-1:0] tap_b,
    input  logic [DW-1:0] tap_x,
    output logic [DW-1:0] new_word,
    output logic [DW-1:0] rnd_word
);
    // Sum truncated to DW bits: carry out is discarded (mod 2^DW).
    assign new_word = tap_a + tap_b;
    assign rnd_word = new_word ^ tap_x;
endmodule

// File: rtl/lagfib_ctrl.sv
module lagfib_ctrl
    import lagfib_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          seed_we,
    input  logic          step_en,
    output wheel_state_t  state_o,
    output logic [AW-1:0] ptr_o,
    output logic [AW-1:0] wr_addr,
    output logic          ring_we,
    output logic          sel_seed,
    output logic          step_go
);
    wheel_state_t  state_q, state_d;
    logic [AW-1:0] ptr_q, ptr_d;
    logic          fill_last;

    assign fill_last = (ptr_q == {AW{1'b1}});

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d  = state_q;
        ptr_d    = ptr_q;
        wr_addr  = ptr_q;
        sel_seed = seed_we;
        step_go  = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                if (seed_we) begin
                    state_d = ST_FILL;
                    ptr_d   = ptr_q + 1'b1;
                end
            end
            ST_FILL: begin
                if (seed_we) begin
                    ptr_d = ptr_q + 1'b1;
                    if (fill_last) begin
                        state_d = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (seed_we) begin
                    state_d = ST_FILL;
                    wr_addr = '0;
                    ptr_d   = AW'(1);
                end else if (step_en) begin
                    step_go = 1'b1;
                    ptr_d   = ptr_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_EMPTY;
                ptr_d   = '0;
            end
        endcase
        ring_we = seed_we || step_go;
    end

    assign state_o = state_q;
    assign ptr_o   = ptr_q;
endmodule

// File: rtl/lagfib_rng.sv
module lagfib_rng
    import lagfib_pkg::*;
#(
    parameter int WORD_W  = lagfib_pkg::WORD_W,
    parameter int RING_AW = lagfib_pkg::RING_AW,
    parameter int LAG_A   = lagfib_pkg::LAG_ADD_A,
    parameter int LAG_B   = lagfib_pkg::LAG_ADD_B,
    parameter int LAG_X   = lagfib_pkg::LAG_MIX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_we,
    input  logic [WORD_W-1:0] seed_data,
    input  logic              step_en,
    output logic [WORD_W-1:0] rnd_out,
    output logic              rnd_valid
);
    localparam logic [RING_AW-1:0] OFS_A = RING_AW'(LAG_A);
    localparam logic [RING_AW-1:0] OFS_B = RING_AW'(LAG_B);
    localparam logic [RING_AW-1:0] OFS_X = RING_AW'(LAG_X);

    wheel_state_t        state;
    logic [RING_AW-1:0]  ptr, wr_addr;
    logic                ring_we, sel_seed, step_go;
    logic [WORD_W-1:0]   tap_a, tap_b, tap_x, new_word, rnd_word, wr_data;

    lagfib_ctrl #(.AW(RING_AW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .seed_we  (seed_we),
        .step_en  (step_en),
        .state_o  (state),
        .ptr_o    (ptr),
        .wr_addr  (wr_addr),
        .ring_we  (ring_we),
        .sel_seed (sel_seed),
        .step_go  (step_go)
    );

    assign wr_data = sel_seed ? seed_data : new_word;

    lagfib_ring #(.DW(WORD_W), .AW(RING_AW)) u_ring (
        .clk       (clk),
        .wr_en     (ring_we),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr_a (ptr - OFS_A),
        .rd_addr_b (ptr - OFS_B),
        .rd_addr_x (ptr - OFS_X),
        .rd_a      (tap_a),
        .rd_b      (tap_b),
        .rd_x      (tap_x)
    );

    lagfib_mix #(.DW(WORD_W)) u_mix (
        .tap_a    (tap_a),
        .tap_b    (tap_b),
        .tap_x    (tap_x),
        .new_word (new_word),
        .rnd_word (rnd_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rnd_out   <= '0;
            rnd_valid <= 1'b0;
        end else begin
            rnd_valid <= step_go;
            if (step_go) begin
                rnd_out <= rnd_word;
            end
        end
    end
endmodule

// File: rtl/lagfib_rng_chk.sv
module lagfib_rng_chk
    import lagfib_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          seed_we,
    input logic          step_en,
    input logic [DW-1:0] rnd_out,
    input logic          rnd_valid,
    input wheel_state_t  state,
    input logic [AW-1:0] ptr
);
    logic go;
    assign go = (state == ST_RUN) && step_en && !seed_we;

    a_r2_no_valid_outside_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN) |-> !rnd_valid);

    a_r3_valid_after_step: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> rnd_valid);

    a_r3_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> (!rnd_valid && $stable(rnd_out)));

    a_r5_index_advances: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (ptr == AW'($past(ptr) + 1'b1)));

    a_r7_reseed_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_we && state == ST_RUN) |=> (state == ST_FILL && ptr == AW'(1) && !rnd_valid));

    a_r2_fill_to_run_only_full: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && !(seed_we && ptr == {AW{1'b1}})) |=> (state != ST_RUN));
endmodule

bind lagfib_rng lagfib_rng_chk #(.DW(WORD_W), .AW(RING_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .seed_we   (seed_we),
    .step_en   (step_en),
    .rnd_out   (rnd_out),
    .rnd_valid (rnd_valid),
    .state     (state),
    .ptr       (ptr)
);

// File: tb/lagfib_rng_bench.sv
`timescale 1ns/1ps
module lagfib_rng_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seed_we = 1'b0;
    logic [31:0] seed_data = '0;
    logic        step_en = 1'b0;
    logic [31:0] rnd_out;
    logic        rnd_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m [64];
    int          mk = 0;
    logic [31:0] last_out = '0;

    always #4 clk = ~clk;

    lagfib_rng u_lagfib_rng (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed_we   (seed_we),
        .seed_data (seed_data),
        .step_en   (step_en),
        .rnd_out   (rnd_out),
        .rnd_valid (rnd_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_step();
        logic [31:0] n, o;
        n = m[(mk - 24) & 63] + m[(mk - 55) & 63];
        o = n ^ m[(mk - 61) & 63];
        m[mk & 63] = n;
        mk++;
        return o;
    endfunction

    // Loads 64 seeds; optionally holds step_en high to show it is ignored (R2)
    task automatic t_seed(input logic [31:0] base, input logic [31:0] mul,
                          input bit with_step, input int first);
        for (int i = first; i < 64; i++) begin
            @(negedge clk);
            if (i > first) chk("R2 valid during seeding", {31'b0, rnd_valid}, 32'd0);
            seed_we   = 1'b1;
            seed_data = base + mul * i;
            step_en   = with_step;
            m[i]      = seed_data;
            @(posedge clk);
        end
        @(negedge clk);
        seed_we = 1'b0;
        step_en = 1'b0;
        chk("R2 valid right after seeding", {31'b0, rnd_valid}, 32'd0);
        mk = 64;
    endtask

    // gap: 0 = step every cycle (R6); otherwise skip every gap-th cycle (R3)
    task automatic t_run(input int n, input int gap, input string req);
        for (int i = 0; i < n; i++) begin
            bit go;
            go = !(gap != 0 && (i % gap) == gap - 1);
            step_en = go;
            @(posedge clk);
            @(negedge clk);
            if (go) begin
                last_out = model_step();
                chk({req, " valid"}, {31'b0, rnd_valid}, 32'd1);
                chk({req, " value"}, rnd_out, last_out);
            end else begin
                chk("R3 no valid without step", {31'b0, rnd_valid}, 32'd0);
                chk("R3 output holds", rnd_out, last_out);
            end
        end
        step_en = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", {31'b0, rnd_valid}, 32'd0);
        chk("R1 out in reset", rnd_out, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", {31'b0, rnd_valid}, 32'd0);
        chk("R1 out after reset", rnd_out, 32'd0);
        step_en = 1'b1;
        @(negedge clk);
        chk("R2 step before seed ignored", {31'b0, rnd_valid}, 32'd0);
        step_en = 1'b0;
    endtask

    task automatic t_reseed();
        @(negedge clk);
        seed_we   = 1'b1;
        seed_data = 32'h0BAD_F00D;
        step_en   = 1'b1;
        m[0]      = seed_data;
        @(posedge clk);
        @(negedge clk);
        chk("R7 valid drops on reseed", {31'b0, rnd_valid}, 32'd0);
        seed_we = 1'b0;
        @(negedge clk);
        chk("R7 no output after single reseed word", {31'b0, rnd_valid}, 32'd0);
        step_en = 1'b0;
        t_seed(32'h1357_9BDF, 32'h0F0F_1234, 1'b1, 1);
    endtask

    initial begin
        t_reset();
        t_seed(32'h0000_0001, 32'h9E37_79B9, 1'b1, 0);
        t_run(1, 0, "R2 first output from seeds R4");
        t_run(1100, 0, "R5 long run R6");
        t_run(90, 3, "R3 gapped run R4");
        t_reseed();
        t_run(150, 0, "R7 after reseed");
        t_seed(32'hFFFF_FFF0, 32'h0000_0001, 1'b0, 0);   // large words force carry
        t_run(200, 0, "R8 carry wrap");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule